// File: doc/BRIEF.md
# Calibration Retention Table Controller

This block keeps the calibration results that a radio receiver has measured, with one small table per receive chain. Each table has six 28-bit entries. Entries 0 to 2 hold the DC offset results (loop, low, high). Entry 3 holds the filter cutoff, entry 4 the receive gain settings and entry 5 the peak detector offset. Software reaches a table through a pair of registers per chain. The command register starts an access: it carries a start bit, a write flag and an entry address. The data register carries the entry value. Hardware clears the start bit when the access has finished. Clearing a table means writing zero to each of its entries through this port.

A global control register holds three things: a retention enable, a restore mask with one bit per entry, and a force-restore trigger. Setting the trigger starts a sequencer. It walks every chain in ascending order and, inside each chain, every entry in ascending order, one slot per clock. For each entry whose mask bit is 0 it presents a valid/chain/index/data write to the radio. The trigger bit reads back as 1 while the walk runs and clears by itself at the end.

Each chain's access port is a two-state machine. It moves from AC_IDLE to AC_BUSY on an accepted start and returns to AC_IDLE after the fixed access time, which is when the table operation commits. The sequencer moves from RS_IDLE to RS_WALK on an accepted trigger and returns to RS_IDLE after the last entry of the last chain.

Top module: `cal_retain_ctrl`

Register map (bus word addresses, 3 chains): 0 is the control register. Chain c has its command register at 2c+1 and its data register at 2c+2. Address 7 is unmapped.

## Requirements
- R1: After reset the control register, every command register and every data register read as 0, and rad_valid is 0.
- R2: The control register keeps bit 0 (enable) and bits 6:1 (restore mask, bit 1+e for entry e) as written. Bit 7 reads 1 only while a replay runs. All other bits read 0.
- R3: A write of a command word with bit 0 (start) set is accepted when enable is 1 and the port is idle. After it, bit 0 of the command register reads 1 for exactly 4 clock cycles and then reads 0. Bit 1 is the write flag and bits 4:2 the entry address.
- R4: A write access copies data register bits 31:4 into the addressed entry. Data register bits 3:0 always read 0.
- R5: When a read access completes, data register bits 31:4 hold the addressed entry.
- R6: While an access is in progress, writes to that chain's command register and data register are ignored. The command fields, the data register and the table stay unchanged.
- R7: While enable is 0, a start write leaves the start bit at 0. A force-restore write then leaves bit 7 at 0 and produces no radio write.
- R8: An accepted force-restore write runs one slot per cycle over chains 0 to 2 and, within each chain, entries 0 to 5 in ascending order. Each slot presents rad_chain, rad_index and the stored entry on rad_data. Bit 7 stays 1 for exactly 18 cycles.
- R9: A mask bit of 1 drops that entry from the replay for every chain. rad_valid is 0 in its slot.
- R10: Replay and table access are mutually exclusive. During a replay, command writes and control writes are ignored. A force-restore write while any access is in progress leaves bit 7 at 0; its enable and mask bits still load.
- R11: An access with entry address 6 or 7 leaves the table unchanged, and a read access at those addresses sets the data register to 0. The unmapped bus address reads 0.
- R12: Each chain's table, command register and data register are independent of the other chains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| rad_valid | output | 1 | Radio write valid |
| rad_chain | output | 2 | Chain of the radio write |
| rad_index | output | 3 | Entry index of the radio write |
| rad_data | output | 28 | Entry value of the radio write |

## Verification
A software table access and a forced replay both want the same table storage, so they are the two functions that could fall in the same cycle. The bench provokes the clash in both orders. In one, it issues a start command and a control write a cycle into a running replay. In the other, it writes the force trigger while an access is still counting. Each is judged at the ports: the command register and the mask must read back unchanged, bit 7 must read 0 when the trigger was refused, and the radio capture must hold exactly the entries predicted from the tables and the mask.

// File: rtl/cal_retain_pkg.sv
package cal_retain_pkg;
    localparam int DATA_W  = 32;
    localparam int LOW_PAD = 4;
    localparam int ENTRY_W = DATA_W - LOW_PAD;

    typedef enum logic {
        AC_IDLE,
        AC_BUSY
    } acc_state_e;

    typedef enum logic {
        RS_IDLE,
        RS_WALK
    } rs_state_e;
endpackage

// File: rtl/cal_access_port.sv
module cal_access_port
    import cal_retain_pkg::*;
#(
    parameter  int ENTRIES    = 6,
    parameter  int ACC_CYCLES = 4,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int CNT_W      = $clog2(ACC_CYCLES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               block,
    input  logic               cmd_we,
    input  logic               data_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [IDX_W-1:0]   rs_idx,
    output logic               busy,
    output logic [DATA_W-1:0]  cmd_rd,
    output logic [DATA_W-1:0]  data_rd,
    output logic [ENTRY_W-1:0] rs_entry
);
    acc_state_e         st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   addr_q;
    logic               wr_q;
    logic [ENTRY_W-1:0] data_q;
    logic [ENTRY_W-1:0] tbl_q [ENTRIES];

    logic cmd_ok, launch, finish, hit;

    assign cmd_ok = cmd_we && (st_q == AC_IDLE) && !block;
    assign launch = cmd_ok && en && wdata[0];
    assign finish = (st_q == AC_BUSY) && (cnt_q == CNT_W'(ACC_CYCLES - 1));
    assign hit    = int'(addr_q) < ENTRIES;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AC_IDLE: if (launch) st_d = AC_BUSY;
            AC_BUSY: if (finish) st_d = AC_IDLE;
            default: st_d = AC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AC_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            data_q <= '0;
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else begin
            if (cmd_ok) begin
                addr_q <= wdata[IDX_W+1:2];
                wr_q   <= wdata[1];
            end
            if (data_we && st_q == AC_IDLE) data_q <= wdata[DATA_W-1:LOW_PAD];
            cnt_q <= (st_q == AC_BUSY) ? cnt_q + 1'b1 : '0;
            if (finish) begin
                if (wr_q) begin
                    if (hit) tbl_q[addr_q] <= data_q;
                end else begin
                    data_q <= hit ? tbl_q[addr_q] : '0;
                end
            end
        end
    end

    assign busy     = (st_q == AC_BUSY);
    assign cmd_rd   = {{(DATA_W-IDX_W-2){1'b0}}, addr_q, wr_q, busy};
    assign data_rd  = {data_q, {LOW_PAD{1'b0}}};
    assign rs_entry = (int'(rs_idx) < ENTRIES) ? tbl_q[rs_idx] : '0;

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wr_q)));
endmodule

// File: rtl/cal_restore_seq.sv
module cal_restore_seq
    import cal_retain_pkg::*;
#(
    parameter  int NUM_CHAINS = 3,
    parameter  int ENTRIES    = 6,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int CH_W       = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [ENTRIES-1:0] mask,
    output logic               busy,
    output logic               slot_hit,
    output logic [CH_W-1:0]    slot_ch,
    output logic [IDX_W-1:0]   slot_idx
);
    rs_state_e        st_q, st_d;
    logic [CH_W-1:0]  ch_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_idx, last_ch;

    assign last_idx = (idx_q == IDX_W'(ENTRIES - 1));
    assign last_ch  = (ch_q == CH_W'(NUM_CHAINS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_IDLE: if (go) st_d = RS_WALK;
            RS_WALK: if (last_idx && last_ch) st_d = RS_IDLE;
            default: st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            idx_q <= '0;
        end else if (st_q == RS_IDLE) begin
            ch_q  <= '0;
            idx_q <= '0;
        end else if (last_idx) begin
            idx_q <= '0;
            ch_q  <= last_ch ? '0 : ch_q + 1'b1;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy     = (st_q == RS_WALK);
    assign slot_hit = busy && !mask[idx_q];
    assign slot_ch  = ch_q;
    assign slot_idx = idx_q;

    // R8
    walk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(idx_q) < ENTRIES && int'(ch_q) < NUM_CHAINS));

    // R8
    walk_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (idx_q == '0 && ch_q == '0));
endmodule

// File: rtl/cal_retain_ctrl.sv
module cal_retain_ctrl
    import cal_retain_pkg::*;
#(
    parameter  int NUM_CHAINS = 3,
    parameter  int ENTRIES    = 6,
    parameter  int ACC_CYCLES = 4,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int CH_W       = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
    localparam int ADDR_W     = $clog2(1 + 2 * NUM_CHAINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               rad_valid,
    output logic [CH_W-1:0]    rad_chain,
    output logic [IDX_W-1:0]   rad_index,
    output logic [ENTRY_W-1:0] rad_data
);
    localparam int FORCE_BIT = ENTRIES + 1;

    logic               ctl_en;
    logic [ENTRIES-1:0] ctl_mask;
    logic               rs_busy, ctrl_we, force_go;
    logic [NUM_CHAINS-1:0] acc_busy;
    logic [DATA_W-1:0]  cmd_rd_all  [NUM_CHAINS];
    logic [DATA_W-1:0]  data_rd_all [NUM_CHAINS];
    logic [ENTRY_W-1:0] ent_all     [NUM_CHAINS];

    assign ctrl_we  = bus_we && (bus_addr == '0) && !rs_busy;
    assign force_go = ctrl_we && bus_wdata[FORCE_BIT] && bus_wdata[0]
                      && ctl_en && (acc_busy == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mask <= '0;
        end else if (ctrl_we) begin
            ctl_en   <= bus_wdata[0];
            ctl_mask <= bus_wdata[ENTRIES:1];
        end
    end

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        logic cmd_we_c, data_we_c;
        assign cmd_we_c  = bus_we && (bus_addr == ADDR_W'(2 * c + 1));
        assign data_we_c = bus_we && (bus_addr == ADDR_W'(2 * c + 2));

        cal_access_port #(
            .ENTRIES    (ENTRIES),
            .ACC_CYCLES (ACC_CYCLES)
        ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ctl_en),
            .block    (rs_busy),
            .cmd_we   (cmd_we_c),
            .data_we  (data_we_c),
            .wdata    (bus_wdata),
            .rs_idx   (rad_index),
            .busy     (acc_busy[c]),
            .cmd_rd   (cmd_rd_all[c]),
            .data_rd  (data_rd_all[c]),
            .rs_entry (ent_all[c])
        );

        // R7
        acc_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(acc_busy[c]) |-> $past(ctl_en));
    end

    cal_restore_seq #(
        .NUM_CHAINS (NUM_CHAINS),
        .ENTRIES    (ENTRIES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (force_go),
        .mask     (ctl_mask),
        .busy     (rs_busy),
        .slot_hit (rad_valid),
        .slot_ch  (rad_chain),
        .slot_idx (rad_index)
    );

    assign rad_data = ent_all[rad_chain];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0)
            bus_rdata = {{(DATA_W-ENTRIES-2){1'b0}}, rs_busy, ctl_mask, ctl_en};
        for (int c = 0; c < NUM_CHAINS; c++) begin
            if (bus_addr == ADDR_W'(2 * c + 1)) bus_rdata = cmd_rd_all[c];
            if (bus_addr == ADDR_W'(2 * c + 2)) bus_rdata = data_rd_all[c];
        end
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_busy && (acc_busy != '0)));

    // R10
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_busy && $past(rs_busy)) |-> ($stable(ctl_mask) && $stable(ctl_en)));

    // R7
    walk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rs_busy) |-> $past(ctl_en));
endmodule

// File: tb/cal_retain_ctrl_tb.sv
`timescale 1ns/1ps
module cal_retain_ctrl_tb;
    localparam int NCH = 3;
    localparam int NE  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rad_valid;
    logic [1:0]  rad_chain;
    logic [2:0]  rad_index;
    logic [27:0] rad_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int          cap_n = 0;
    logic [1:0]  cap_ch  [64];
    logic [2:0]  cap_ix  [64];
    logic [27:0] cap_dat [64];
    logic [27:0] model [NCH][NE];

    always #2 clk = ~clk;

    cal_retain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rad_valid(rad_valid),
        .rad_chain(rad_chain), .rad_index(rad_index), .rad_data(rad_data)
    );

    always @(negedge clk) begin
        if (rst_n && rad_valid && cap_n < 64) begin
            cap_ch[cap_n]  <= rad_chain;
            cap_ix[cap_n]  <= rad_index;
            cap_dat[cap_n] <= rad_data;
            cap_n          <= cap_n + 1;
        end
    end

    function automatic logic [27:0] pat(int c, int e, int salt);
        return 28'((c + 1) * 32'h0A5C31E7 + e * 32'h01100113 + salt * 32'h00F0F0F1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = 3'(a);
        #1 d = bus_rdata;
    endtask

    // full access with start-bit timing check (R3)
    task automatic access(int c, int e, bit w, logic [27:0] d);
        logic [31:0] v;
        if (w) wr(2 * c + 2, {d, 4'hF});
        wr(2 * c + 1, {27'b0, 3'(e), w, 1'b1});
        rd(2 * c + 1, v); chk("R3 start high", 32'(v[0]), 1);
        repeat (3) @(negedge clk);
        rd(2 * c + 1, v); chk("R3 start high at cycle 4", 32'(v[0]), 1);
        @(negedge clk);
        rd(2 * c + 1, v); chk("R3 start cleared", v, {27'b0, 3'(e), w, 1'b0});
    endtask

    task automatic replay(logic [5:0] m);
        logic [31:0] v;
        int cnt, k;
        cap_n = 0;
        wr(0, {24'b0, 1'b1, m, 1'b1});
        cnt = 0;
        rd(0, v);
        while (v[7]) begin
            cnt++;
            @(negedge clk);
            rd(0, v);
        end
        chk("R8 force bit length", 32'(cnt), NCH * NE);
        chk("R2 ctrl after replay", v, {24'b0, 1'b0, m, 1'b1});
        k = 0;
        for (int c = 0; c < NCH; c++)
            for (int e = 0; e < NE; e++)
                if (!m[e]) begin
                    if (k < cap_n) begin
                        chk("R8 radio chain", 32'(cap_ch[k]), 32'(c));
                        chk("R9 radio index", 32'(cap_ix[k]), 32'(e));
                        chk("R8 radio data", 32'(cap_dat[k]), 32'(model[c][e]));
                    end
                    k++;
                end
        chk("R9 radio write count", 32'(cap_n), 32'(k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        logic [31:0] v, prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state and unmapped address
        for (int a = 0; a < 8; a++) begin
            rd(a, v); chk("R1 reset register", v, 0);
        end
        chk("R1 rad_valid", 32'(rad_valid), 0);

        // R7: disabled block ignores start and force
        wr(1, 32'h0000_0007);
        rd(1, v); chk("R7 start stays 0", 32'(v[0]), 0);
        cap_n = 0;
        wr(0, 32'h0000_0080);
        rd(0, v); chk("R7 force stays 0", v, 0);
        repeat (4) @(negedge clk);
        chk("R7 no radio write", 32'(cap_n), 0);

        // R2: control layout
        wr(0, 32'hFFFF_FF7F);
        rd(0, v); chk("R2 ctrl readback", v, 32'h0000_007F);
        wr(0, 32'h0000_0001);
        rd(0, v); chk("R2 ctrl enable", v, 32'h0000_0001);

        // R4/R12: fill every entry of every chain
        for (int c = 0; c < NCH; c++)
            for (int e = 0; e < NE; e++) begin
                model[c][e] = pat(c, e, 0);
                access(c, e, 1'b1, model[c][e]);
            end
        // R5/R12: read them back
        for (int c = 0; c < NCH; c++)
            for (int e = 0; e < NE; e++) begin
                access(c, e, 1'b0, 28'h0);
                rd(2 * c + 2, v); chk("R5 read entry", v, {model[c][e], 4'h0});
            end
        // R4: low data bits read zero
        wr(2, 32'hFFFF_FFFF);
        rd(2, v); chk("R4 low bits zero", v, 32'hFFFF_FFF0);

        // R6: writes during access ignored
        wr(4, {28'h1234567, 4'h0});
        wr(3, {27'b0, 3'd0, 1'b0, 1'b1});
        wr(3, {27'b0, 3'd2, 1'b1, 1'b1});
        wr(4, {28'hBADBEEF, 4'h0});
        rd(3, v); chk("R6 cmd fields held", v, {27'b0, 3'd0, 1'b0, 1'b1});
        repeat (3) @(negedge clk);
        rd(4, v); chk("R6 read result kept", v, {model[1][0], 4'h0});
        access(1, 2, 1'b0, 28'h0);
        rd(4, v); chk("R6 table untouched", v, {model[1][2], 4'h0});

        // R11: out-of-range entry addresses
        access(0, 6, 1'b1, 28'hFFFFFFF);
        access(0, 7, 1'b0, 28'h0);
        rd(2, v); chk("R11 read addr 7 zero", v, 0);
        access(0, 6, 1'b0, 28'h0);
        rd(2, v); chk("R11 read addr 6 zero", v, 0);
        access(0, 5, 1'b0, 28'h0);
        rd(2, v); chk("R11 entry 5 intact", v, {model[0][5], 4'h0});

        // R8/R9: replay under every mask
        for (int m = 0; m < 64; m++) replay(6'(m));

        // R10: force during an access
        cap_n = 0;
        wr(6, 32'h0);
        wr(5, {27'b0, 3'd1, 1'b0, 1'b1});
        wr(0, {24'b0, 1'b1, 6'h05, 1'b1});
        rd(0, v); chk("R10 force refused", v, {24'b0, 1'b0, 6'h05, 1'b1});
        repeat (25) @(negedge clk);
        chk("R10 no radio write", 32'(cap_n), 0);

        // R10: command and control writes during a replay
        rd(1, prev);
        cap_n = 0;
        wr(0, 32'h0000_0081);
        wr(1, {27'b0, 3'd3, 1'b1, 1'b1});
        wr(0, 32'h0000_007F);
        rd(1, v); chk("R10 cmd ignored in replay", v, prev);
        repeat (20) @(negedge clk);
        rd(0, v); chk("R10 ctrl ignored in replay", v, 32'h0000_0001);
        chk("R10 full replay count", 32'(cap_n), NCH * NE);
        access(0, 3, 1'b0, 28'h0);
        rd(2, v); chk("R10 entry not written", v, {model[0][3], 4'h0});

        // table clear, then replay zeros
        for (int c = 0; c < NCH; c++)
            for (int e = 0; e < NE; e++) begin
                model[c][e] = '0;
                access(c, e, 1'b1, 28'h0);
            end
        replay(6'h00);

        // R12: refill with a different pattern, chains stay distinct
        for (int c = 0; c < NCH; c++)
            for (int e = 0; e < NE; e++) begin
                model[c][e] = pat(c, e, c + 3);
                access(c, e, 1'b1, model[c][e]);
            end
        replay(6'h10);

        // R7: disable again, force ignored
        wr(0, 32'h0000_0000);
        cap_n = 0;
        wr(0, 32'h0000_0080);
        rd(0, v); chk("R7 force ignored when disabled", v, 0);
        repeat (20) @(negedge clk);
        chk("R7 no replay when disabled", 32'(cap_n), 0);

        summary();
    end
endmodule